// File: doc/BRIEF.md
# Prescaled Timer With Write Resync

An 8-bit free-running count register advanced by a power-of-two clock divider (or by every clock when the divider is bypassed). When the count rolls over from its top value to zero, an interrupt request is raised and held until software acknowledges it. Software can load the count at any time through a write port.

Every load also zeroes the divider phase. Under a coarse divide ratio, this lets software stretch the next period by an exact number of clocks: software waits a chosen number of clocks after the rollover, then reloads. A load also freezes counting for a short interval whose length depends on the divide setting, so the first increment after a load lands at a fixed, known distance.

A small option field chooses the divide ratio or bypass. Writing the option field also zeroes the divider phase.

Top module: `tmr_resync_top`

## Requirements
- R1: The option field is 4 bits. Bits 2:0 hold a select value s, and bit 3 is bypass. With bypass clear, the count advances once every 2^(s+1) clocks. With bypass set, it advances on every clock. A write of 4'h4 gives divide-by-32.
- R2: A count write loads the write data on that clock edge. It takes priority over any increment or rollover due on the same edge, so no interrupt is raised by that edge.
- R3: With a divide ratio of 8 or more, the first increment after a count write happens exactly ratio edges after the write edge.
- R4: With bypass set, the first increment after a count write happens 3 edges after the write edge.
- R5: With a divide ratio of 2 or 4, the first increment after a count write happens ratio + 4 edges after the write edge.
- R6: A rollover from 255 to 0 sets the interrupt request. The request stays set until the acknowledge input is high on an edge. If a rollover and an acknowledge arrive on the same edge, the request is set.
- R7: An option write zeroes the divider phase and suppresses the increment on its own edge. With the new ratio at 8 or more, the next increment follows that ratio's number of edges later.
- R8: After reset, the count is 0, the request is low, and bypass is in force, so the count advances on every clock.
- R9: Under divide-by-32, loading 100 exactly 24 edges after a rollover edge makes the next rollover fall 5016 edges after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Option field write strobe |
| opt_wdata | input | 4 | Option data: bit 3 bypass, bits 2:0 divide select |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count load value |
| cnt_rdata | output | 8 | Current count |
| irq | output | 1 | Rollover interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The hardest situations to reach are two collisions. In the first, a count write lands on the very edge where a rollover was due. In the second, an option write lands while the freeze after a count write is still running. Random traffic rarely lines these up. Directed sequences therefore first place the count one step below rollover under bypass, then write on the exact edge of the due rollover. The random phase biases load values toward the top of the range and mixes in option writes at low rate, so that freezes, phase resets and rollovers overlap under every divide setting. All of it is compared cycle by cycle against a bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W = 3;
  localparam int OPT_W = SEL_W + 1;

  typedef struct packed {
    logic             bypass;
    logic [SEL_W-1:0] sel;
  } opt_t;
endpackage

// File: rtl/tmr_opt_reg.sv
module tmr_opt_reg
  import tmr_pkg::*;
#(
  parameter logic [OPT_W-1:0] RST_OPT = 4'h8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OPT_W-1:0] wdata,
  output opt_t             opt
);
  opt_t opt_q, opt_d;

  always_comb begin
    opt_d = opt_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  opt_q <= opt_t'(RST_OPT);
    else if (we) opt_q <= opt_d;
  end

  assign opt = opt_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int INH_DIV1     = 2,
  parameter int INH_FINE     = 4,
  parameter int FINE_MAX_SEL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  opt_t opt,
  input  logic cnt_we,
  input  logic opt_we,
  output logic tick
);
  localparam int PS_W    = 1 << SEL_W;
  localparam int INH_MAX = (INH_DIV1 > INH_FINE) ? INH_DIV1 : INH_FINE;
  localparam int INH_W   = $clog2(INH_MAX + 1);

  logic [PS_W-1:0]  pre_q, pre_d, pre_last;
  logic [INH_W-1:0] inh_q, inh_d, inh_len;
  logic             busy, wr_any, at_last, pre_en, inh_en;

  // terminal phase: low (sel+1) bits set
  for (genvar i = 0; i < PS_W; i++) begin : g_last
    assign pre_last[i] = (SEL_W'(i) <= opt.sel);
  end

  always_comb begin
    busy    = (inh_q != '0);
    wr_any  = cnt_we | opt_we;
    at_last = (pre_q == pre_last);
    if (opt.bypass)                        inh_len = INH_W'(INH_DIV1);
    else if (opt.sel <= SEL_W'(FINE_MAX_SEL)) inh_len = INH_W'(INH_FINE);
    else                                   inh_len = '0;
    tick    = !wr_any && !busy && (opt.bypass || at_last);
  end

  always_comb begin
    pre_en = wr_any || (!busy && !opt.bypass);
    if (wr_any || at_last) pre_d = '0;
    else                   pre_d = pre_q + 1'b1;
  end

  always_comb begin
    inh_en = cnt_we || busy;
    if (cnt_we) inh_d = inh_len;
    else        inh_d = inh_q - INH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inh_q <= '0;
    else if (inh_en) inh_q <= inh_d;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d, wrap, cnt_en, irq_en;

  always_comb begin
    wrap   = !ld && tick && (&cnt_q);
    cnt_en = ld || tick;
    cnt_d  = ld ? ld_data : cnt_q + 1'b1;
    irq_en = wrap || ack;
    irq_d  = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/tmr_resync_top.sv
module tmr_resync_top
  import tmr_pkg::*;
#(
  parameter int               CNT_W        = 8,
  parameter logic [OPT_W-1:0] RST_OPT      = 4'h8,
  parameter int               INH_DIV1     = 2,
  parameter int               INH_FINE     = 4,
  parameter int               FINE_MAX_SEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_we,
  input  logic [OPT_W-1:0] opt_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             irq,
  input  logic             irq_ack
);
  opt_t opt_q;
  logic tick;

  tmr_opt_reg #(.RST_OPT(RST_OPT)) u_opt (
    .clk(clk), .rst_n(rst_n), .we(opt_we), .wdata(opt_wdata), .opt(opt_q)
  );

  tmr_prescale #(
    .INH_DIV1(INH_DIV1), .INH_FINE(INH_FINE), .FINE_MAX_SEL(FINE_MAX_SEL)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .opt(opt_q), .cnt_we(cnt_we), .opt_we(opt_we),
    .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_we), .ld_data(cnt_wdata),
    .ack(irq_ack), .cnt(cnt_rdata), .irq(irq)
  );
endmodule

// File: rtl/tmr_resync_chk.sv
module tmr_resync_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             opt_we,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             irq,
  input logic             irq_ack,
  input logic             bypass
);
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_rdata == $past(cnt_wdata))); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_rdata == $past(cnt_rdata) ||
                 cnt_rdata == CNT_W'($past(cnt_rdata) + 1'b1))); // R1

  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt_rdata == '0)); // R6

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R6

  AST_DIV1_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_we) && !$past(opt_we) && bypass && !cnt_we)
      |=> $stable(cnt_rdata)); // R4
endmodule

bind tmr_resync_top tmr_resync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .cnt_we(cnt_we),
  .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .irq(irq),
  .irq_ack(irq_ack), .bypass(opt_q.bypass)
);

// File: tb/tb_tmr_resync_top.sv
`timescale 1ns/1ps
module tb_tmr_resync_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       opt_we, cnt_we, irq_ack;
  logic [3:0] opt_wdata;
  logic [7:0] cnt_wdata;
  logic [7:0] cnt_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [7:0] m_cnt;
  logic [3:0] m_opt;
  logic       m_irq;
  int         m_pre, m_inh;

  tmr_resync_top dut (
    .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .irq(irq), .irq_ack(irq_ack)
  );

  always #2 clk = ~clk;

  function automatic int ratio_of(input logic [3:0] o);
    if (o[3]) return 1;
    return 1 << (int'(o[2:0]) + 1);
  endfunction

  function automatic int freeze_of(input logic [3:0] o);
    int r = ratio_of(o);
    if (r == 1) return 2;
    if (r < 8)  return 4;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic owe, input logic [3:0] od,
                            input logic cwe, input logic [7:0] cd, input logic ack);
    int  r   = ratio_of(m_opt);
    bit  adv = !cwe && !owe && (m_inh == 0) && (r == 1 || m_pre == r - 1);
    int  np, ni;
    if (cwe || owe)      np = 0;
    else if (m_inh != 0) np = m_pre;
    else if (r == 1)     np = 0;
    else                 np = (m_pre == r - 1) ? 0 : m_pre + 1;
    if (cwe)             ni = freeze_of(m_opt);
    else                 ni = (m_inh != 0) ? m_inh - 1 : 0;
    if (adv && m_cnt == 8'hFF) m_irq = 1'b1;
    else if (ack)              m_irq = 1'b0;
    if (cwe)      m_cnt = cd;
    else if (adv) m_cnt = m_cnt + 8'd1;
    if (owe) m_opt = od;
    m_pre = np;
    m_inh = ni;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic owe, input logic [3:0] od,
                      input logic cwe, input logic [7:0] cd, input logic ack);
    opt_we = owe; opt_wdata = od; cnt_we = cwe; cnt_wdata = cd; irq_ack = ack;
    @(posedge clk);
    model_edge(owe, od, cwe, cd, ack);
    @(negedge clk);
    opt_we = 0; cnt_we = 0; irq_ack = 0;
    chk(cnt_rdata == m_cnt, "R1 R2 count vs model", cnt_rdata, m_cnt);
    chk(irq == m_irq, "R6 irq vs model", irq, m_irq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 4'h0, 0, 8'h00, 0);
  endtask

  task automatic gap_after_write(input logic [7:0] v, output int n);
    step(0, 4'h0, 1, v, 0);
    n = 0;
    while (cnt_rdata == v && n < 2000) begin
      step(0, 4'h0, 0, 8'h00, 0);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] v;
    void'($urandom(32'd1234));
    rst_n = 0; opt_we = 0; cnt_we = 0; irq_ack = 0; opt_wdata = 0; cnt_wdata = 0;
    m_cnt = 0; m_opt = 4'h8; m_irq = 0; m_pre = 0; m_inh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state, then bypass counting
    chk(cnt_rdata == 8'd0, "R8 reset count", cnt_rdata, 0);
    chk(irq == 1'b0, "R8 reset irq", irq, 0);
    idle(5);
    chk(cnt_rdata == 8'd5, "R8 bypass after reset", cnt_rdata, 5);

    // R4: bypass write gap
    gap_after_write(8'd10, n);
    chk(n == 3, "R4 div1 first increment", n, 3);

    // R5: ratio 2 and 4
    step(1, 4'h0, 0, 8'h00, 0);
    gap_after_write(8'd20, n);
    chk(n == 6, "R5 div2 first increment", n, 6);
    step(1, 4'h1, 0, 8'h00, 0);
    gap_after_write(8'd30, n);
    chk(n == 8, "R5 div4 first increment", n, 8);

    // R3 / R1: coarse ratios
    step(1, 4'h2, 0, 8'h00, 0);
    gap_after_write(8'd40, n);
    chk(n == 8, "R3 div8 first increment", n, 8);
    step(1, 4'h4, 0, 8'h00, 0);
    gap_after_write(8'd50, n);
    chk(n == 32, "R3 R1 div32 first increment", n, 32);
    gap_after_write(8'd51, n); n = 0;
    v = cnt_rdata;
    while (cnt_rdata == v && n < 100) begin idle(1); n++; end
    chk(n == 32, "R1 div32 steady period", n, 32);
    step(1, 4'h7, 0, 8'h00, 0);
    gap_after_write(8'd60, n);
    chk(n == 256, "R3 div256 first increment", n, 256);

    // R7: option write resets phase
    idle(7);
    v = cnt_rdata;
    step(1, 4'h3, 0, 8'h00, 0);
    n = 0;
    while (cnt_rdata == v && n < 100) begin idle(1); n++; end
    chk(n == 16, "R7 option write phase reset", n, 16);

    // R6: rollover and hold
    step(1, 4'h8, 0, 8'h00, 1);
    step(0, 4'h0, 1, 8'hFD, 0);
    n = 0;
    while (!irq && n < 20) begin idle(1); n++; end
    chk(n == 5, "R6 irq edge after load FD", n, 5);
    chk(cnt_rdata == 8'd0, "R6 count at rollover", cnt_rdata, 0);
    idle(4);
    chk(irq == 1'b1, "R6 irq held without ack", irq, 1);
    step(0, 4'h0, 0, 8'h00, 1);
    chk(irq == 1'b0, "R6 irq cleared by ack", irq, 0);
    // R6: rollover beats ack on same edge
    step(0, 4'h0, 1, 8'hFF, 1);
    step(0, 4'h0, 0, 8'h00, 1);
    step(0, 4'h0, 0, 8'h00, 1);
    step(0, 4'h0, 0, 8'h00, 1);
    chk(irq == 1'b1, "R6 set wins over ack", irq, 1);
    step(0, 4'h0, 0, 8'h00, 1);
    chk(irq == 1'b0, "R6 later ack clears", irq, 0);

    // R2: write on edge of due rollover
    step(0, 4'h0, 1, 8'hFE, 0);
    idle(3);
    chk(cnt_rdata == 8'hFF, "R2 setup at top", cnt_rdata, 255);
    step(0, 4'h0, 1, 8'h40, 0);
    chk(cnt_rdata == 8'h40, "R2 load wins", cnt_rdata, 64);
    chk(irq == 1'b0, "R2 no irq on load edge", irq, 0);

    // R9: 5016-clock period at divide-by-32
    step(1, 4'h4, 1, 8'hFF, 1);
    n = 0;
    while (!irq && n < 200) begin idle(1); n++; end
    step(0, 4'h0, 0, 8'h00, 1);
    idle(22);
    step(0, 4'h0, 1, 8'd100, 0);
    n = 24;
    while (!irq && n < 6000) begin idle(1); n++; end
    chk(n == 5016, "R9 stretched period", n, 5016);

    // random phase
    for (int i = 0; i < 15000; i++) begin
      logic       owe = ($urandom_range(0, 299) == 0);
      logic       cwe = ($urandom_range(0, 39) == 0);
      logic       ack = ($urandom_range(0, 7) == 0);
      logic [3:0] od  = 4'($urandom);
      logic [7:0] cd  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(240, 255))
                                                      : 8'($urandom);
      step(owe, od, cwe, cd, ack);
    end
    finish_run();
  end
endmodule